// File: doc/BRIEF.md
# Prioritized Port Pin Multiplexer

This block runs a 16-pin general-purpose port built from two 8-bit halves. Each pin can be claimed by one of three owners. A frontplane segment driver has the highest priority. An external bus that presents address or read-visibility data comes next. Plain GPIO, controlled by a data register and a direction register, has the lowest priority. For every pin the block computes the pad output value, the output enable and the pull-down enable. It also serves a byte-wide register bus that reads and writes the data and direction registers of both halves.

The segment driver claims a pin only when its global enable and that pin's enable are both set. The external bus claims a pin through a per-pin enable. Both owners provide a per-pin output value. The pin index matches the bit index of the frontplane and bus vectors: the upper half carries bits 15..8 and the lower half carries bits 7..0. Pad inputs pass through a two-stage synchronizer before a register read returns them.

The register bus is a plain control interface with no back-pressure. A write completes on the clock edge where `reg_en` and `reg_we` are both high. Read data is combinational from the current state while `reg_en` is high and `reg_we` is low.

Top module: `pinmux_port16`

## Requirements
- R1: Out of reset, with both the segment and bus owners disabled, every pad has its output enable at 0 and its pull-down at 1, and all four registers read 0 while the pads are low.
- R2: Pin ownership follows a fixed priority: segment driver first, then external bus, then GPIO.
- R3: The segment driver owns pin i only when `seg_glb_en` and `seg_pin_en[i]` are both 1. While it owns the pin, the pad drives `seg_val[i]` with the output enable at 1 and the pull-down at 0.
- R4: When the external bus owns pin i (`xbus_en[i]`=1 and no segment ownership), the pad drives `xbus_val[i]` with the output enable at 1 and the pull-down at 0.
- R5: A GPIO-owned pin drives its data bit. Its output enable equals its direction bit, and its pull-down is the inverse of the direction bit.
- R6: The address map is: 0x50 lower data, 0x51 upper data, 0x52 lower direction, 0x53 upper direction. Register bit k maps to pin k of its half. A write takes effect on the pads right after its clock edge.
- R7: A data-register read returns the stored bit for every pin whose direction bit is 1.
- R8: A data-register read returns 1 for every input pin (direction 0) that the segment driver owns.
- R9: A data-register read returns the pad level for an input pin that the segment driver does not own. A pad change becomes visible after exactly two rising clock edges.
- R10: Writes to a data or direction register are stored even while a higher-priority owner holds the pins. The stored value reaches the pads as soon as GPIO regains ownership.
- R11: Reads of addresses outside 0x50..0x53 return 0, and writes to them change no register. `reg_rdata` is 0 while `reg_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| seg_glb_en | input | 1 | Global segment driver enable |
| seg_pin_en | input | 16 | Per-pin frontplane enable |
| seg_val | input | 16 | Per-pin frontplane value |
| xbus_en | input | 16 | Per-pin external bus ownership |
| xbus_val | input | 16 | Per-pin external bus value |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_pd | output | 16 | Pad pull-down enables |

## Verification
Pad outputs react in the same cycle to changes in owner enables and values. They react one edge after a register write. The bench therefore drives inputs at the falling edge and samples the pads one nanosecond later, or one falling edge after a write. Pad input levels reach read data only after two rising edges. The bench changes `pad_in` at a falling edge, reads the old value after the first rising edge and the new value after the second, which checks the exact latency. Register reads are combinational, so each read is sampled within the same low clock phase in which the bench drives it.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NUM_HALVES = 2;
  localparam int SYNC_STAGES = 2;

  localparam logic [7:0] OFS_DAT_LO = 8'h50;
  localparam logic [7:0] OFS_DAT_HI = 8'h51;
  localparam logic [7:0] OFS_DIR_LO = 8'h52;
  localparam logic [7:0] OFS_DIR_HI = 8'h53;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_XBUS = 2'd1,
    OWN_SEG  = 2'd2
  } owner_e;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int ADDR_W = 8,
  localparam int PIN_W = NUM_HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [PIN_W-1:0]  dat_q,
  output logic [PIN_W-1:0]  dir_q
);
  logic wr;
  assign wr = reg_en & reg_we;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT_LO) + ADDR_W'(h);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR_LO) + ADDR_W'(h);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[h*HALF_W +: HALF_W] <= '0;
        dir_q[h*HALF_W +: HALF_W] <= '0;
      end else if (wr) begin
        if (reg_addr == A_DAT) dat_q[h*HALF_W +: HALF_W] <= reg_wdata;
        if (reg_addr == A_DIR) dir_q[h*HALF_W +: HALF_W] <= reg_wdata;
      end
    end
  end
endmodule

// File: rtl/pinmux_arb.sv
module pinmux_arb
  import pinmux_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             seg_glb_en,
  input  logic [PIN_W-1:0] seg_pin_en,
  input  logic [PIN_W-1:0] seg_val,
  input  logic [PIN_W-1:0] xbus_en,
  input  logic [PIN_W-1:0] xbus_val,
  input  logic [PIN_W-1:0] dat_q,
  input  logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] seg_own,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pad_pd
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    owner_e own;

    always_comb begin
      if (seg_glb_en && seg_pin_en[i]) own = OWN_SEG;
      else if (xbus_en[i])             own = OWN_XBUS;
      else                             own = OWN_GPIO;
    end

    always_comb begin
      unique case (own)
        OWN_SEG: begin
          pad_out[i] = seg_val[i];
          pad_oe[i]  = 1'b1;
          pad_pd[i]  = 1'b0;
        end
        OWN_XBUS: begin
          pad_out[i] = xbus_val[i];
          pad_oe[i]  = 1'b1;
          pad_pd[i]  = 1'b0;
        end
        default: begin
          pad_out[i] = dat_q[i];
          pad_oe[i]  = dir_q[i];
          pad_pd[i]  = ~dir_q[i];
        end
      endcase
    end

    assign seg_own[i] = (own == OWN_SEG);
  end
endmodule

// File: rtl/pinmux_rdmux.sv
module pinmux_rdmux
  import pinmux_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int ADDR_W = 8,
  localparam int PIN_W = NUM_HALVES * HALF_W
) (
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PIN_W-1:0]  dat_q,
  input  logic [PIN_W-1:0]  dir_q,
  input  logic [PIN_W-1:0]  seg_own,
  input  logic [PIN_W-1:0]  pin_sync,
  output logic [HALF_W-1:0] reg_rdata
);
  logic [PIN_W-1:0] dat_view;

  // per pin: output -> stored bit, segment-held input -> 1, else pad level
  for (genvar i = 0; i < PIN_W; i++) begin : g_view
    assign dat_view[i] = dir_q[i] ? dat_q[i] : (seg_own[i] | pin_sync[i]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we) begin
      for (int h = 0; h < NUM_HALVES; h++) begin
        if (reg_addr == ADDR_W'(OFS_DAT_LO) + ADDR_W'(h))
          reg_rdata = dat_view[h*HALF_W +: HALF_W];
        if (reg_addr == ADDR_W'(OFS_DIR_LO) + ADDR_W'(h))
          reg_rdata = dir_q[h*HALF_W +: HALF_W];
      end
    end
  end
endmodule

// File: rtl/pinmux_port16.sv
module pinmux_port16
  import pinmux_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int ADDR_W = 8,
  localparam int PIN_W = NUM_HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  input  logic              seg_glb_en,
  input  logic [PIN_W-1:0]  seg_pin_en,
  input  logic [PIN_W-1:0]  seg_val,
  input  logic [PIN_W-1:0]  xbus_en,
  input  logic [PIN_W-1:0]  xbus_val,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pad_pd
);
  logic [PIN_W-1:0] dat_q, dir_q, seg_own, pin_sync;

  pinmux_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dat_q(dat_q), .dir_q(dir_q)
  );

  pinmux_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
  );

  pinmux_arb #(.PIN_W(PIN_W)) u_arb (
    .seg_glb_en(seg_glb_en), .seg_pin_en(seg_pin_en), .seg_val(seg_val),
    .xbus_en(xbus_en), .xbus_val(xbus_val),
    .dat_q(dat_q), .dir_q(dir_q), .seg_own(seg_own),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd)
  );

  pinmux_rdmux #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_rd (
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .dat_q(dat_q), .dir_q(dir_q), .seg_own(seg_own), .pin_sync(pin_sync),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk #(
  parameter int HALF_W = 8,
  parameter int ADDR_W = 8,
  localparam int PIN_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [HALF_W-1:0] reg_wdata,
  input logic [HALF_W-1:0] reg_rdata,
  input logic              seg_glb_en,
  input logic [PIN_W-1:0]  seg_pin_en,
  input logic [PIN_W-1:0]  seg_val,
  input logic [PIN_W-1:0]  xbus_en,
  input logic [PIN_W-1:0]  xbus_val,
  input logic [PIN_W-1:0]  pad_out,
  input logic [PIN_W-1:0]  pad_oe,
  input logic [PIN_W-1:0]  pad_pd
);
  logic [PIN_W-1:0] segm, xm, gm;
  assign segm = {PIN_W{seg_glb_en}} & seg_pin_en;
  assign xm   = xbus_en & ~segm;
  assign gm   = ~(segm | xbus_en);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    (!rst_n && !seg_glb_en && xbus_en == '0) |-> (pad_oe == '0 && pad_pd == '1));

  // R3
  seg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ seg_val) & segm) == '0) && ((segm & ~pad_oe) == '0) && ((segm & pad_pd) == '0));

  // R4
  xbus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ xbus_val) & xm) == '0) && ((xm & ~pad_oe) == '0) && ((xm & pad_pd) == '0));

  // R5
  gpio_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pd ^ ~pad_oe) & gm) == '0);

  // R6
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == ADDR_W'(8'h52) && !seg_glb_en && xbus_en == '0)
    |=> (seg_glb_en || xbus_en != '0 || pad_oe[HALF_W-1:0] == $past(reg_wdata)));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en || reg_we || reg_addr < ADDR_W'(8'h50) || reg_addr > ADDR_W'(8'h53))
    |-> reg_rdata == '0);
endmodule

bind pinmux_port16 pinmux_chk #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .seg_glb_en(seg_glb_en), .seg_pin_en(seg_pin_en), .seg_val(seg_val),
  .xbus_en(xbus_en), .xbus_val(xbus_val),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd)
);

// File: tb/sim_pinmux_port16.sv
`timescale 1ns/1ps
module sim_pinmux_port16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        seg_glb_en = 1'b0;
  logic [15:0] seg_pin_en = '0, seg_val = '0, xbus_en = '0, xbus_val = '0, pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_pd;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pinmux_port16 u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seg_glb_en(seg_glb_en), .seg_pin_en(seg_pin_en), .seg_val(seg_val),
    .xbus_en(xbus_en), .xbus_val(xbus_val), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk); #1;
    chk("R1 oe", pad_oe, 16'h0000);
    chk("R1 pd", pad_pd, 16'hFFFF);
    for (int a = 8'h50; a <= 8'h53; a++) begin
      rd(8'(a), d);
      chk("R1 rd", {8'h00, d}, 16'h0000);
    end
    rd(8'h50, d);
    reg_en = 1'b0; #0.1;
    chk("R11 idle rdata", {8'h00, reg_rdata}, 16'h0000);
  endtask

  task automatic t_gpio();
    logic [7:0] d;
    pad_in = 16'h0030;
    wr(8'h52, 8'h0F);
    wr(8'h50, 8'hA5);
    #1;
    chk("R5 oe", pad_oe, 16'h000F);
    chk("R5 pd", pad_pd, 16'hFFF0);
    chk("R5 out", {8'h00, pad_out[7:0]}, 16'h00A5);
    rd(8'h52, d);
    chk("R6 dir rd", {8'h00, d}, 16'h000F);
    rd(8'h50, d);
    chk("R7 R9 dat rd", {8'h00, d}, 16'h0035);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    @(negedge clk);
    pad_in = 16'h5A30;
    @(negedge clk);
    rd(8'h51, d);
    chk("R9 one edge", {8'h00, d}, 16'h0000);
    @(negedge clk);
    rd(8'h51, d);
    chk("R9 two edges", {8'h00, d}, 16'h005A);
  endtask

  task automatic t_seg();
    logic [7:0] d;
    @(negedge clk);
    pad_in = 16'h0000;
    seg_glb_en = 1'b1; seg_pin_en = 16'h01F0; seg_val = 16'h0150;
    repeat (2) @(negedge clk);
    #1;
    chk("R3 out", pad_out & 16'h01F0, 16'h0150);
    chk("R3 oe", pad_oe, 16'h01FF);
    chk("R3 pd", pad_pd, 16'hFE00);
    rd(8'h50, d);
    chk("R8 dat lo", {8'h00, d}, 16'h00F5);
    rd(8'h51, d);
    chk("R8 dat hi", {8'h00, d}, 16'h0001);
    seg_glb_en = 1'b0; #1;
    chk("R3 glb off oe", pad_oe, 16'h000F);
    rd(8'h50, d);
    chk("R3 glb off rd", {8'h00, d}, 16'h0005);
  endtask

  task automatic t_prio();
    @(negedge clk);
    seg_glb_en = 1'b1; seg_pin_en = 16'h00F0; seg_val = 16'h00A0;
    xbus_en = 16'hFFFF; xbus_val = 16'h1234;
    #1;
    chk("R2 out", pad_out, 16'h12A4);
    chk("R4 oe", pad_oe, 16'hFFFF);
    chk("R4 pd", pad_pd, 16'h0000);
    seg_glb_en = 1'b0; #1;
    chk("R4 out", pad_out, 16'h1234);
  endtask

  task automatic t_shadow();
    logic [7:0] d;
    wr(8'h51, 8'hC3);
    wr(8'h53, 8'hFF);
    #1;
    chk("R10 held", pad_out, 16'h1234);
    xbus_en = 16'h0000; #1;
    chk("R10 out", pad_out[15:8], 16'h00C3);
    chk("R10 oe", pad_oe, 16'hFF0F);
    rd(8'h51, d);
    chk("R10 rd", {8'h00, d}, 16'h00C3);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(8'h54, 8'hFF);
    wr(8'h4F, 8'hFF);
    #1;
    chk("R11 pads", pad_oe, 16'hFF0F);
    rd(8'h54, d);
    chk("R11 rd 54", {8'h00, d}, 16'h0000);
    rd(8'h4F, d);
    chk("R11 rd 4F", {8'h00, d}, 16'h0000);
    rd(8'h52, d);
    chk("R11 dir kept", {8'h00, d}, 16'h000F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_gpio();
    t_sync();
    t_seg();
    t_prio();
    t_shadow();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule